// File: doc/BRIEF.md
# Serial ADC Host Controller

This block reads a 12-bit successive-approximation converter over a three-wire serial link. It drives a conversion strobe and a serial clock made from the system clock, and takes in a single data line from the converter. A conversion begins when the strobe falls. Every conversion uses a frame of sixteen serial clock cycles. The converter shifts out three padding zeros and then twelve result bits, MSB first, changing its data line on rising serial clock edges. The controller drops the padding, rebuilds the 12-bit word and marks it with a one-cycle valid pulse.

The serial clock half-period is set in system clock cycles and is never shorter than a floor taken from the system frequency, so the serial clock cannot run faster than 28.8 MHz. Clock polarity and phase are both selectable. Single-shot mode holds the strobe low until the frame is over, so the converter lets go of its data line. Continuous mode raises the strobe late in the frame and chains the next conversion right after it, which gives the highest throughput. The host side uses a start pulse, a busy level and a result with a valid strobe.

Top module: `sadc_host`

## Requirements
- R1: After reset, and whenever the block is idle, the strobe is high, busy and resultValid are low, and the serial clock rests at the cfgCpol level from one cycle after that input is applied.
- R2: A start while idle drives the strobe low on the next cycle and produces one frame of exactly 16 serial clock cycles (32 edges) that begins and ends at the polarity level.
- R3: Each serial clock half-period lasts max(cfgHalf, MIN_HALF) system cycles, where MIN_HALF = ceil(SYS_HZ / (2 * MAX_SCLK_HZ)). With the default 100 MHz system clock, MIN_HALF is 2.
- R4: The converter changes its data on rising serial clock edges. When cfgCpol equals cfgCpha, the block samples on the next rising edge. Otherwise it samples on the falling edge that follows that rising edge.
- R5: Of the 15 bits sampled in a frame, the first three are padding and are discarded whatever their value. The next 12 bits form the result, MSB first.
- R6: resultValid is a one-cycle pulse. It is high in the cycle that follows the serial clock edge which samples the 15th bit. That edge is rising edge 16 when cfgCpol equals cfgCpha, and otherwise the falling edge after rising edge 15. Rising edge k is edge 2k-1 when cfgCpol is 0 and edge 2k when it is 1.
- R7: In continuous mode (cfgCont=1), the strobe rises together with the 15th rising serial clock edge. When another start is queued, the strobe falls again one half-period after the 32nd edge.
- R8: In single-shot mode (cfgCont=0), the strobe stays low through the 32nd edge and rises one half-period after it. busy then stays high, and the strobe stays high, for at least two more half-periods before the next fall.
- R9: A start that arrives while busy is held (one deep) and run as the next frame in continuous mode. In single-shot mode it is ignored, which means no extra strobe fall and no extra result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one conversion |
| cfgHalf | input | HALF_W | Serial clock half-period in system cycles (raised to MIN_HALF if lower) |
| cfgCpol | input | 1 | Serial clock idle level |
| cfgCpha | input | 1 | Serial clock phase select |
| cfgCont | input | 1 | 1 = continuous chaining, 0 = single-shot |
| busy | output | 1 | A frame or the post-frame gap is in progress |
| result | output | 12 | Last converted value |
| resultValid | output | 1 | One-cycle pulse when result updates |
| adcCnvst | output | 1 | Conversion strobe to the converter (falling edge starts) |
| adcSclk | output | 1 | Serial clock to the converter |
| adcDout | input | 1 | Serial data from the converter |

## Verification
A wrong edge count or a wrong capture decode shows up at once in the result word: bits move by one or more places, or padding leaks into the MSBs, in the same frame. It also moves the valid pulse off the expected serial clock edge. A half-period timer or strobe sequencer in the wrong state shows up within one frame as a measured half-period of the wrong length, a strobe that rises at the wrong rising-edge count, or a gap between frames of the wrong length. A wrong pending flag shows up as a missing or extra strobe fall and result before busy drops.

// File: rtl/sadc_host_pkg.sv
package sadc_host_pkg;

  // Frame geometry of the converter link
  localparam int unsigned SCLK_PER_FRAME = 16;
  localparam int unsigned PAD_BITS       = 3;
  localparam int unsigned DATA_BITS      = 12;
  localparam int unsigned CAP_BITS       = PAD_BITS + DATA_BITS;
  localparam int unsigned FRAME_EDGES    = 2 * SCLK_PER_FRAME;

  // Strobes from control to datapath
  typedef struct packed {
    logic park;        // idle: hold serial clock at polarity level
    logic frameStart;  // new conversion begins
    logic toggle;      // serial clock edge this cycle
    logic capture;     // sample data line at this edge
    logic lastCapture; // this sample completes the frame
  } dpStrobe_t;

endpackage

// File: rtl/sadc_host_ctrl.sv
module sadc_host_ctrl
  import sadc_host_pkg::*;
#(
  parameter int HALF_W   = 8,
  parameter int MIN_HALF = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [HALF_W-1:0] cfgHalf,
  input  logic              cfgCpol,
  input  logic              cfgCpha,
  input  logic              cfgCont,
  output logic              busy,
  output logic              cnvst,
  output dpStrobe_t         st
);

  localparam int EW = $clog2(FRAME_EDGES + 1);
  localparam logic [EW-1:0]     LAST_EDGE  = EW'(FRAME_EDGES);
  localparam logic [EW-1:0]     CAP_LAST   = EW'(CAP_BITS);
  localparam logic [EW-1:0]     RAISE_RISE = EW'(SCLK_PER_FRAME - 1);
  localparam logic [EW-1:0]     LOW_EDGES  = EW'(FRAME_EDGES - 4);
  localparam logic [HALF_W-1:0] MIN_H      = HALF_W'(MIN_HALF);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} state_t;

  state_t            state;
  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] halfQ;
  logic [HALF_W-1:0] halfEff;
  logic [EW-1:0]     edgeCnt;
  logic              cpolQ, cphaQ, contQ;
  logic              pending;
  logic              gapDone;
  logic              cnvstQ;

  logic              tick, toggleNow, endNow, accept, chainNow;
  logic [EW-1:0]     nextEdge, riseIdx, fallIdx, capIdx;
  logic              isRise, capHit, raiseNow;

  assign halfEff   = (cfgHalf < MIN_H) ? MIN_H : cfgHalf;
  assign tick      = (state != S_IDLE) && (cnt == '0);
  assign toggleNow = (state == S_RUN) && tick && (edgeCnt < LAST_EDGE);
  assign endNow    = (state == S_RUN) && tick && (edgeCnt == LAST_EDGE);
  assign accept    = (state == S_IDLE) && start;
  assign chainNow  = endNow && contQ && (pending || start);

  // Work out which edge comes next and whether it samples
  always_comb begin
    nextEdge = edgeCnt + EW'(1);
    isRise   = nextEdge[0] ^ cpolQ;
    riseIdx  = (nextEdge + {{(EW-1){1'b0}}, ~cpolQ}) >> 1;
    fallIdx  = nextEdge >> 1;
    if (cpolQ == cphaQ) begin
      capHit = isRise && (riseIdx >= EW'(2)) && (riseIdx <= CAP_LAST + EW'(1));
      capIdx = riseIdx - EW'(1);
    end else begin
      capHit = !isRise && (fallIdx >= EW'(1)) && (fallIdx <= CAP_LAST);
      capIdx = fallIdx;
    end
    raiseNow = contQ && isRise && (riseIdx == RAISE_RISE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      halfQ   <= MIN_H;
      edgeCnt <= '0;
      cpolQ   <= 1'b0;
      cphaQ   <= 1'b0;
      contQ   <= 1'b0;
      pending <= 1'b0;
      gapDone <= 1'b0;
      cnvstQ  <= 1'b1;
    end else begin
      if (tick)                 cnt <= halfQ - HALF_W'(1);
      else if (state != S_IDLE) cnt <= cnt - HALF_W'(1);
      case (state)
        S_IDLE: begin
          if (start) begin
            cpolQ   <= cfgCpol;
            cphaQ   <= cfgCpha;
            contQ   <= cfgCont;
            halfQ   <= halfEff;
            cnt     <= halfEff - HALF_W'(1);
            edgeCnt <= '0;
            cnvstQ  <= 1'b0;
            pending <= 1'b0;
            state   <= S_RUN;
          end
        end
        S_RUN: begin
          if (start && contQ) pending <= 1'b1;
          if (toggleNow) begin
            edgeCnt <= nextEdge;
            if (raiseNow) cnvstQ <= 1'b1;
          end
          if (endNow) begin
            if (contQ) begin
              if (pending || start) begin
                edgeCnt <= '0;
                cnvstQ  <= 1'b0;
                pending <= 1'b0;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              cnvstQ  <= 1'b1;
              gapDone <= 1'b0;
              state   <= S_GAP;
            end
          end
        end
        S_GAP: begin
          if (tick) begin
            if (gapDone) state <= S_IDLE;
            else         gapDone <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy  = (state != S_IDLE);
  assign cnvst = cnvstQ;

  always_comb begin
    st.park        = (state == S_IDLE);
    st.frameStart  = accept || chainNow;
    st.toggle      = toggleNow;
    st.capture     = toggleNow && capHit;
    st.lastCapture = toggleNow && capHit && (capIdx == CAP_LAST);
  end

  // Single-shot: strobe low for the whole frame and tail (R8)
  assert_single_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && !contQ) |-> !cnvst);

  // Single-shot gap: strobe high while still busy (R8)
  assert_gap_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_GAP) |-> (cnvst && busy));

  // Continuous: strobe still low up to the 14th rising edge (R7)
  assert_cont_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && contQ && edgeCnt < LOW_EDGES) |-> !cnvst);

  // Continuous: strobe already high once all edges are out (R7)
  assert_cont_raised_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && contQ && edgeCnt == LAST_EDGE) |-> cnvst);

endmodule

// File: rtl/sadc_host_dp.sv
module sadc_host_dp
  import sadc_host_pkg::*;
#(
  parameter int HALF_W   = 8,
  parameter int MIN_HALF = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            st,
  input  logic                 cfgCpol,
  input  logic                 adcDout,
  output logic                 adcSclk,
  output logic [DATA_BITS-1:0] result,
  output logic                 resultValid
);

  logic                 sclkQ, sclkNext;
  logic [DATA_BITS-2:0] shiftQ;
  logic [DATA_BITS-1:0] resultQ;
  logic                 validQ;

  always_comb begin
    if (st.park)        sclkNext = cfgCpol;
    else if (st.toggle) sclkNext = ~sclkQ;
    else                sclkNext = sclkQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      shiftQ  <= '0;
      resultQ <= '0;
      validQ  <= 1'b0;
    end else begin
      sclkQ  <= sclkNext;
      validQ <= st.lastCapture;
      if (st.frameStart)  shiftQ  <= '0;
      else if (st.capture) shiftQ <= {shiftQ[DATA_BITS-3:0], adcDout};
      if (st.lastCapture) resultQ <= {shiftQ, adcDout};
    end
  end

  assign adcSclk     = sclkQ;
  assign result      = resultQ;
  assign resultValid = validQ;

  // Checker: count how long the serial clock has held its level
  logic [HALF_W:0] holdCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   holdCnt <= '1;
    else if (sclkNext != sclkQ)  holdCnt <= (HALF_W+1)'(1);
    else if (holdCnt != '1)      holdCnt <= holdCnt + (HALF_W+1)'(1);
  end

  assert_half_min_R3: assert property (@(posedge clk) disable iff (!rstN)
    st.toggle |-> (holdCnt >= (HALF_W+1)'(MIN_HALF)));

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rstN)
    st.park |=> (adcSclk == $past(cfgCpol)));

endmodule

// File: rtl/sadc_host.sv
module sadc_host
  import sadc_host_pkg::*;
#(
  parameter int SYS_HZ      = 100_000_000,
  parameter int MAX_SCLK_HZ = 28_800_000,
  parameter int HALF_W      = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [HALF_W-1:0]    cfgHalf,
  input  logic                 cfgCpol,
  input  logic                 cfgCpha,
  input  logic                 cfgCont,
  output logic                 busy,
  output logic [DATA_BITS-1:0] result,
  output logic                 resultValid,
  output logic                 adcCnvst,
  output logic                 adcSclk,
  input  logic                 adcDout
);

  localparam int MIN_RAW  = (SYS_HZ + 2 * MAX_SCLK_HZ - 1) / (2 * MAX_SCLK_HZ);
  localparam int MIN_HALF = (MIN_RAW < 1) ? 1 : MIN_RAW;

  dpStrobe_t st;

  sadc_host_ctrl #(.HALF_W(HALF_W), .MIN_HALF(MIN_HALF)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .cfgHalf (cfgHalf),
    .cfgCpol (cfgCpol),
    .cfgCpha (cfgCpha),
    .cfgCont (cfgCont),
    .busy    (busy),
    .cnvst   (adcCnvst),
    .st      (st)
  );

  sadc_host_dp #(.HALF_W(HALF_W), .MIN_HALF(MIN_HALF)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .cfgCpol     (cfgCpol),
    .adcDout     (adcDout),
    .adcSclk     (adcSclk),
    .result      (result),
    .resultValid (resultValid)
  );

endmodule

// File: tb/sim_sadc_host.sv
module sim_sadc_host;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_W     = 8;
  localparam int SYS_HZ     = 100_000_000;
  localparam int MAX_HZ     = 28_800_000;
  localparam int MIN_EXP    = (SYS_HZ + 2 * MAX_HZ - 1) / (2 * MAX_HZ);

  logic              clk, rstN, start, cfgCpol, cfgCpha, cfgCont;
  logic [HALF_W-1:0] cfgHalf;
  logic              busy, resultValid, adcCnvst, adcSclk, adcDout;
  logic [11:0]       result;

  sadc_host #(.SYS_HZ(SYS_HZ), .MAX_SCLK_HZ(MAX_HZ), .HALF_W(HALF_W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .cfgHalf(cfgHalf),
    .cfgCpol(cfgCpol), .cfgCpha(cfgCpha), .cfgCont(cfgCont),
    .busy(busy), .result(result), .resultValid(resultValid),
    .adcCnvst(adcCnvst), .adcSclk(adcSclk), .adcDout(adcDout)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- converter model ----------------
  logic [11:0] devQ[$];
  logic [11:0] expQ[$];
  logic [11:0] curWord = '0;
  bit          padOnes = 0;
  int          riseCnt = 0;

  always @(negedge adcCnvst) begin
    riseCnt = 0;
    adcDout <= 1'b0;
    if (devQ.size() > 0) curWord = devQ.pop_front();
    else                 curWord = '0;
  end

  always @(posedge adcSclk) begin
    riseCnt = riseCnt + 1;
    if (riseCnt <= 3)       adcDout <= padOnes;
    else if (riseCnt <= 15) adcDout <= curWord[15 - riseCnt];
    else                    adcDout <= 1'b0;
  end

  // ---------------- expectation state ----------------
  bit cpolExp = 0, cphaExp = 0, contExp = 0, armed = 0;
  int halfExp = MIN_EXP;

  function automatic int riseEdge(input bit cpol, input int k);
    return cpol ? 2 * k : 2 * k - 1;
  endfunction

  function automatic int lastEdgeExp(input bit cpol, input bit cpha);
    if (cpol == cpha) return riseEdge(cpol, 16);
    return riseEdge(cpol, 15) + 1;
  endfunction

  // ---------------- monitor / scoreboard ----------------
  bit prevCnvst = 1, prevSclk = 0, prevBusy = 0, prevValid = 0, haveRise = 0;
  int togCnt = 0, lastTogCyc = 0, edge32Cyc = 0, riseCyc = 0;
  int minIv = 1000000, maxIv = 0;
  int resCount = 0, fallCount = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      prevCnvst = 1; prevSclk = adcSclk; prevBusy = 0; prevValid = 0;
    end else begin
      if (!adcCnvst && prevCnvst) begin
        fallCount++;
        if (armed && contExp && prevBusy)
          chk(cyc - edge32Cyc == halfExp, "R7 chained strobe fall delay", cyc - edge32Cyc, halfExp);
        if (armed && !contExp && haveRise)
          chk(cyc - riseCyc >= 2 * halfExp, "R8 strobe high gap", cyc - riseCyc, 2 * halfExp);
        togCnt = 0;
      end
      if (adcCnvst && !prevCnvst && armed) begin
        if (contExp) begin
          chk(riseCnt == 15, "R7 strobe rise at rising edge", riseCnt, 15);
        end else begin
          chk(togCnt == 32, "R2 edges per frame", togCnt, 32);
          chk(adcSclk == cpolExp, "R2 serial clock end level", adcSclk, cpolExp);
          chk(cyc - edge32Cyc == halfExp, "R8 strobe rise delay", cyc - edge32Cyc, halfExp);
          haveRise = 1;
          riseCyc  = cyc;
        end
      end
      if (adcSclk != prevSclk) begin
        togCnt++;
        if (togCnt >= 2 && togCnt <= 32) begin
          if (cyc - lastTogCyc < minIv) minIv = cyc - lastTogCyc;
          if (cyc - lastTogCyc > maxIv) maxIv = cyc - lastTogCyc;
        end
        lastTogCyc = cyc;
        if (togCnt == 32) edge32Cyc = cyc;
      end
      if (resultValid) begin
        resCount++;
        chk(!prevValid, "R6 valid single cycle", prevValid, 0);
        chk(togCnt == lastEdgeExp(cpolExp, cphaExp), "R6 valid edge (R4 sample edge)",
            togCnt, lastEdgeExp(cpolExp, cphaExp));
        if (expQ.size() == 0) begin
          chk(0, "R9 unexpected result", result, -1);
        end else begin
          logic [11:0] e;
          e = expQ.pop_front();
          chk(result == e, "R5 result value", result, e);
        end
      end
      prevCnvst = adcCnvst; prevSclk = adcSclk; prevBusy = busy; prevValid = resultValid;
    end
  end

  // ---------------- driver ----------------
  task automatic setCfg(input int h, input bit cpol, input bit cpha, input bit cont);
    @(negedge clk);
    cfgHalf = HALF_W'(h); cfgCpol = cpol; cfgCpha = cpha; cfgCont = cont;
    cpolExp = cpol; cphaExp = cpha; contExp = cont;
    halfExp = (h < MIN_EXP) ? MIN_EXP : h;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic queueWord(input logic [11:0] w);
    devQ.push_back(w);
    expQ.push_back(w);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic runFrame(input logic [11:0] w, input string tag);
    minIv = 1000000; maxIv = 0;
    queueWord(w);
    pulseStart();
    waitIdle();
    chk(minIv == halfExp && maxIv == halfExp, {"R3 half-period ", tag}, minIv, halfExp);
  endtask

  initial begin
    rstN = 0; start = 0; cfgHalf = '0; cfgCpol = 0; cfgCpha = 0; cfgCont = 0;
    adcDout = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(adcCnvst == 1'b1, "R1 strobe idle high", adcCnvst, 1);
    chk(busy == 1'b0, "R1 busy low", busy, 0);
    chk(resultValid == 1'b0, "R1 valid low", resultValid, 0);
    chk(adcSclk == 1'b0, "R1 clock at polarity 0", adcSclk, 0);
    cfgCpol = 1;
    repeat (2) @(negedge clk);
    chk(adcSclk == 1'b1, "R1 clock follows polarity 1", adcSclk, 1);
    armed = 1;

    // R4/R5 all four phase modes, single-shot
    setCfg(3, 0, 0, 0); runFrame(12'hA5C, "mode00");
    setCfg(3, 0, 1, 0); runFrame(12'h3F1, "mode01");
    setCfg(4, 1, 0, 0); runFrame(12'h800, "mode10");
    setCfg(0, 1, 1, 0); runFrame(12'h001, "mode11 floor");  // R3 floor
    setCfg(1, 0, 0, 0); runFrame(12'h7FE, "below floor");   // R3 floor

    // R5 padding bits driven high must not reach the result
    padOnes = 1;
    setCfg(2, 0, 1, 0); runFrame(12'h000, "pad ones zero");
    runFrame(12'hFFF, "pad ones full");
    padOnes = 0;

    // R9 single-shot: start while busy is ignored; R8 gap before next fall
    begin
      int r0, f0;
      setCfg(3, 1, 0, 0);
      r0 = resCount; f0 = fallCount;
      queueWord(12'h5A5);
      pulseStart();
      repeat (20) @(negedge clk);
      pulseStart();
      waitIdle();
      chk(resCount - r0 == 1, "R9 single ignores busy start (results)", resCount - r0, 1);
      chk(fallCount - f0 == 1, "R9 single ignores busy start (strobes)", fallCount - f0, 1);
      queueWord(12'h0F0);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      waitIdle();
    end

    // R7/R9 continuous: queued start chains a second frame
    begin
      int r0, f0;
      setCfg(2, 0, 1, 1);
      r0 = resCount; f0 = fallCount;
      queueWord(12'h123);
      queueWord(12'hEDC);
      pulseStart();
      repeat (10) @(negedge clk);
      pulseStart();
      waitIdle();
      chk(resCount - r0 == 2, "R9 continuous queues start (results)", resCount - r0, 2);
      chk(fallCount - f0 == 2, "R9 continuous queues start (strobes)", fallCount - f0, 2);
    end

    // R7 continuous single request then idle, other polarity
    begin
      int r0;
      setCfg(5, 1, 1, 1);
      r0 = resCount;
      runFrame(12'h9B6, "continuous cpol1");
      chk(resCount - r0 == 1, "R7 continuous lone frame", resCount - r0, 1);
      chk(adcCnvst == 1'b1 && busy == 1'b0, "R1 idle after continuous", busy, 0);
    end

    chk(expQ.size() == 0, "R9 all expected results seen", expQ.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule